// File: doc/BRIEF.md
# Round-Robin Iterative Crossbar Matcher

This block computes, once per cell slot, the set of input-to-output connections for an N by N input-queued crossbar. Each input keeps a separate logical queue for every output, so a cell held up for one output never holds up cells bound for another. Every input shows which of those queues hold cells. The matcher turns these occupancy bits into a conflict-free pairing: no input is joined to two outputs, and no output to two inputs.

A slot starts with a one-cycle start pulse. The request bits are captured at that edge. The block then runs a fixed number of request-grant-accept rounds, one per clock. In each round every unmatched output grants the first requesting unmatched input at or after its rotating pointer. Every unmatched input then accepts the first granting output at or after its own pointer. The pointers move only in the first round, and only for grants that were accepted. This spreads service fairly over time and keeps the outputs from staying in lockstep. Later rounds only fill in pairs that are still free.

The control is a three-state machine:
- **IDLE**: waits for start. IDLE goes to RUN when start is high, and otherwise stays in IDLE.
- **RUN**: performs one round per cycle. RUN goes to DONE after the last round, and otherwise stays in RUN.
- **DONE**: raises the done pulse for one cycle. DONE always returns to IDLE.

Top module: `rr_xbar_matcher`

## Requirements
- R1: After reset, done_o is low, match_vld_o is zero, and every input and output pointer is 0.
- R2: A valid pairing of input i with output o is reported only if request bit i*N+o was set in the captured request vector. The field for input i is match_o[i*IW +: IW], with IW = log2(N).
- R3: No output is paired with two inputs in one slot, and an input that is already paired gains no further pairing.
- R4: Every output grants the first requesting unmatched input in cyclic order starting at the output's own pointer.
- R5: Every input accepts the first granting output in cyclic order starting at the input's own pointer.
- R6: When a grant is accepted, the output pointer becomes (accepted input + 1) mod N and the input pointer becomes (accepted output + 1) mod N. A grant that is not accepted moves no pointer.
- R7: Pointers change only in the first round of a slot.
- R8: With NUM_ITER >= N, the result is maximal: no request has both its input and its output left unpaired.
- R9: done_o is high for exactly one cycle, NUM_ITER+1 clock edges after the edge that sampled start_i. match_o and match_vld_o stay unchanged until the next accepted start. The field of an unpaired input reads 0.
- R10: A start pulse that arrives while a slot is in progress is ignored, together with its request vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a slot; sampled only in IDLE |
| req_i | input | N*N | Queue occupancy; bit i*N+o set means input i holds a cell for output o |
| done_o | output | 1 | One-cycle pulse: the matching is ready |
| match_o | output | N*IW | Output index chosen for each input, packed by input |
| match_vld_o | output | N | Bit i set means input i has been paired |

## Verification
The assertions assume that start_i is a clean pulse and that req_i holds its value at the edge where start is sampled. They also assume that the maximality check applies only when the round count is at least N, which is the default. The bench drives start and the requests on falling edges and keeps start high for a single cycle. The one exception is the test that deliberately repeats start during a busy slot. The vector table runs from reset in a fixed order, so each expected pairing follows from the pointer values left by the earlier slots. A final reset shows that the pointers return to zero.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rrm_state_e;
endpackage

// File: rtl/rrm_rr_pick.sv
// Rotating first-set picker: searches req cyclically starting at ptr.
module rrm_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (int'(ptr) + k) % N;
            if (!any && req[c]) begin
                any    = 1'b1;
                gnt[c] = 1'b1;
                idx    = IW'(c);
            end
        end
    end
endmodule

// File: rtl/rrm_iter_stage.sv
// One combinational request-grant-accept round over the free inputs/outputs.
module rrm_iter_stage #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N*N-1:0]  req,
    input  logic [N-1:0]    in_free,
    input  logic [N-1:0]    out_free,
    input  logic [N*IW-1:0] gptr,
    input  logic [N*IW-1:0] aptr,
    output logic [N-1:0]    acc_vld,
    output logic [N*IW-1:0] acc_idx,
    output logic [N-1:0]    out_acc,
    output logic [N*IW-1:0] gidx
);
    logic [N-1:0] oreq   [N];
    logic [N-1:0] ogrant [N];
    logic [N-1:0] igrant [N];
    logic [N-1:0] iacc   [N];
    logic [N-1:0] ogany;

    // request matrix seen by each output
    always_comb begin
        for (int o = 0; o < N; o++)
            for (int i = 0; i < N; i++)
                oreq[o][i] = req[i*N+o] & in_free[i] & out_free[o];
    end

    // grant arbiters, one per output
    for (genvar g = 0; g < N; g++) begin : g_grant
        rrm_rr_pick #(.N(N), .IW(IW)) u_pick (
            .req (oreq[g]),
            .ptr (gptr[g*IW +: IW]),
            .gnt (ogrant[g]),
            .idx (gidx[g*IW +: IW]),
            .any (ogany[g])
        );
    end

    always_comb begin
        for (int i = 0; i < N; i++)
            for (int o = 0; o < N; o++)
                igrant[i][o] = ogrant[o][i];
    end

    // accept arbiters, one per input
    for (genvar g = 0; g < N; g++) begin : g_accept
        rrm_rr_pick #(.N(N), .IW(IW)) u_pick (
            .req (igrant[g]),
            .ptr (aptr[g*IW +: IW]),
            .gnt (iacc[g]),
            .idx (acc_idx[g*IW +: IW]),
            .any (acc_vld[g])
        );
    end

    always_comb begin
        for (int o = 0; o < N; o++) begin
            logic taken;
            taken = 1'b0;
            for (int i = 0; i < N; i++)
                taken = taken | iacc[i][o];
            out_acc[o] = ogany[o] & taken;
        end
    end
endmodule

// File: rtl/rr_xbar_matcher.sv
module rr_xbar_matcher #(
    parameter int N        = 4,
    parameter int NUM_ITER = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [N*N-1:0]             req_i,
    output logic                       done_o,
    output logic [N*$clog2(N)-1:0]     match_o,
    output logic [N-1:0]               match_vld_o
);
    import rrm_pkg::*;

    localparam int IW  = $clog2(N);
    localparam int ITW = (NUM_ITER > 1) ? $clog2(NUM_ITER) : 1;

    rrm_state_e st, st_nx;
    logic [ITW-1:0]  iter_q;
    logic [N*N-1:0]  req_q;
    logic [N-1:0]    mvld_q;
    logic [N-1:0]    obusy_q;
    logic [N*IW-1:0] match_q;
    logic [N*IW-1:0] gptr_q;
    logic [N*IW-1:0] aptr_q;

    logic [N-1:0]    acc_vld;
    logic [N*IW-1:0] acc_idx;
    logic [N-1:0]    out_acc;
    logic [N*IW-1:0] gidx;
    logic            last_iter;

    assign last_iter = (iter_q == ITW'(NUM_ITER-1));

    rrm_iter_stage #(.N(N), .IW(IW)) u_stage (
        .req      (req_q),
        .in_free  (~mvld_q),
        .out_free (~obusy_q),
        .gptr     (gptr_q),
        .aptr     (aptr_q),
        .acc_vld  (acc_vld),
        .acc_idx  (acc_idx),
        .out_acc  (out_acc),
        .gidx     (gidx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: st_nx = start_i   ? ST_RUN  : ST_IDLE;
            ST_RUN:  st_nx = last_iter ? ST_DONE : ST_RUN;
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        done_o      = (st == ST_DONE);
        match_o     = match_q;
        match_vld_o = mvld_q;
    end

    // datapath and pointer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter_q  <= '0;
            req_q   <= '0;
            mvld_q  <= '0;
            obusy_q <= '0;
            match_q <= '0;
            gptr_q  <= '0;
            aptr_q  <= '0;
        end else begin
            if (st == ST_IDLE && start_i) begin
                iter_q  <= '0;
                req_q   <= req_i;
                mvld_q  <= '0;
                obusy_q <= '0;
                match_q <= '0;
            end else if (st == ST_RUN) begin
                iter_q  <= iter_q + ITW'(1);
                obusy_q <= obusy_q | out_acc;
                for (int i = 0; i < N; i++) begin
                    if (acc_vld[i]) begin
                        mvld_q[i]            <= 1'b1;
                        match_q[i*IW +: IW]  <= acc_idx[i*IW +: IW];
                        if (iter_q == '0)
                            aptr_q[i*IW +: IW] <= (acc_idx[i*IW +: IW] == IW'(N-1)) ?
                                                  '0 : acc_idx[i*IW +: IW] + IW'(1);
                    end
                end
                if (iter_q == '0) begin
                    for (int o = 0; o < N; o++) begin
                        if (out_acc[o])
                            gptr_q[o*IW +: IW] <= (gidx[o*IW +: IW] == IW'(N-1)) ?
                                                  '0 : gidx[o*IW +: IW] + IW'(1);
                    end
                end
            end
        end
    end

    // ---------------- assertions ----------------
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && iter_q != '0) |=> ($stable(gptr_q) && $stable(aptr_q)));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !start_i) |=> ($stable(match_o) && $stable(match_vld_o)));

    for (genvar i = 0; i < N; i++) begin : g_in_chk
        assert_pair_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && match_vld_o[i]) |-> req_q[i*N + int'(match_o[i*IW +: IW])]);
        assert_in_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (st == ST_RUN && acc_vld[i]) |-> !mvld_q[i]);
        assert_out_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (st == ST_RUN && out_acc[i]) |-> !obusy_q[i]);
        for (genvar j = i + 1; j < N; j++) begin : g_pair
            assert_out_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (done_o && match_vld_o[i] && match_vld_o[j]) |->
                (match_o[i*IW +: IW] != match_o[j*IW +: IW]));
        end
    end

    if (NUM_ITER >= N) begin : g_max_chk
        for (genvar i = 0; i < N; i++) begin : g_i
            for (genvar o = 0; o < N; o++) begin : g_o
                assert_maximal_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    (done_o && req_q[i*N+o]) |-> (match_vld_o[i] || obusy_q[o]));
            end
        end
    end
endmodule

// File: tb/sim_rr_xbar_matcher.sv
`timescale 1ns/1ps
module sim_rr_xbar_matcher;
    localparam int N = 4;
    localparam int NUM_ITER = 4;
    localparam int IW = 2;
    localparam int NV = 7;

    // stimulus and expected results, run in order from reset (pointers evolve)
    localparam logic [15:0] V_REQ [NV] = '{16'hFFFF, 16'hFFFF, 16'h0800, 16'h1010,
                                           16'h1010, 16'h0000, 16'h0005};
    localparam logic [3:0]  V_VLD [NV] = '{4'hF, 4'hF, 4'h4, 4'h8, 4'h2, 4'h0, 4'h1};
    localparam logic [7:0]  V_MAT [NV] = '{8'hE4, 8'hE1, 8'h30, 8'h00, 8'h00, 8'h00, 8'h02};
    localparam string       V_TAG [NV] = '{"R4", "R6", "R5", "R4", "R6", "R2", "R5"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*N-1:0] req = '0;
    logic done;
    logic [N*IW-1:0] match;
    logic [N-1:0] mvld;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rr_xbar_matcher #(.N(N), .NUM_ITER(NUM_ITER)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .req_i(req),
        .done_o(done), .match_o(match), .match_vld_o(mvld)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // structural checks on a finished result against its request vector
    task automatic check_legal(input logic [15:0] r);
        bit used [N];
        bit ok2 = 1'b1, ok3 = 1'b1, ok8 = 1'b1;
        for (int o = 0; o < N; o++) used[o] = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (mvld[i]) begin
                int o;
                o = int'(match[i*IW +: IW]);
                if (!r[i*N+o]) ok2 = 1'b0;
                if (used[o]) ok3 = 1'b0;
                used[o] = 1'b1;
            end
        end
        for (int i = 0; i < N; i++)
            for (int o = 0; o < N; o++)
                if (r[i*N+o] && !mvld[i] && !used[o]) ok8 = 1'b0;
        check(ok2, "R2 pair without request", {24'd0, match}, {16'd0, r});
        check(ok3, "R3 output shared", {24'd0, match}, 32'd0);
        check(ok8, "R8 not maximal", {28'd0, mvld}, {16'd0, r});
    endtask

    // one slot: returns after the done cycle has been checked
    task automatic run_slot(input logic [15:0] r, input logic [3:0] ev,
                            input logic [7:0] em, input string tag, input bit busy_poke);
        int lat = 0;
        @(negedge clk); start = 1'b1; req = r;
        @(negedge clk); start = 1'b0; lat = 1;
        if (busy_poke) begin
            @(negedge clk); lat++;
            start = 1'b1; req = 16'hFFFF;   // R10: must be ignored
            @(negedge clk); lat++;
            start = 1'b0; req = 16'h0000;
        end
        while (!done && lat < 20) begin
            @(negedge clk); lat++;
        end
        check(lat == NUM_ITER + 1, "R9 latency", lat, NUM_ITER + 1);
        check(mvld == ev, {tag, " valid"}, {28'd0, mvld}, {28'd0, ev});
        check(match == em, {tag, " match"}, {24'd0, match}, {24'd0, em});
        check_legal(r);
        @(negedge clk);
        check(!done, "R9 done single cycle", {31'd0, done}, 32'd0);
        check(mvld == ev && match == em, "R9 result held",
              {20'd0, mvld, match}, {20'd0, ev, em});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done && mvld == '0, "R1 reset state", {27'd0, done, mvld}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done, "R1 idle without start", {31'd0, done}, 32'd0);

        for (int v = 0; v < NV; v++)
            run_slot(V_REQ[v], V_VLD[v], V_MAT[v], V_TAG[v], 1'b0);

        // R10: second start during a running slot is dropped
        run_slot(16'h0800, 4'h4, 8'h30, "R10", 1'b1);

        // R1: reset returns pointers to 0, so full request gives identity (R7 too)
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        run_slot(16'hFFFF, 4'hF, 8'hE4, "R1 R7", 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule